// File: doc/BRIEF.md
# Synchronized Multi-Core Halt Controller

This block coordinates stop and restart across the processors and peripherals of one chip while they are being debugged. Each core reports two things: a flag that is high while it sits in its own debug state, and a flag that is high when its debugger is ready to let it run again. When a participating core enters debug, the controller stops every other participating core through a dedicated halt line. It also halts every participating peripheral, such as a timer or a DMA engine. The debugger of each core needs no change.

Each core is tracked in one of three states: running, debugging (held by its own debugger) or halted (held by this controller). A participation mask selects which cores and peripherals take part. The system is released only when the debugger of every debugging core reports ready. At that point all halt lines drop and every debugging core gets a one-cycle resume pulse, all on the same clock edge. A sticky source record shows which cores started the current halt.

Top module: `sync_halt_ctrl`

## Requirements
- R1: Each debug-entry input passes through a two-flop synchronizer. If a core's entry input is high before clock edge k, the halt lines of the other participating cores are high after edge k+2 and still low after edge k+1.
- R2: While the system is idle, a rising edge of a participating core's synchronized entry starts a system halt. That core goes to DEBUG and every other participating core goes to HALT.
- R3: The state of core i is reported on core_state_o[2i+1:2i], with RUN=2'b00, DEBUG=2'b01 and HALT=2'b10. core_halt_o[i] is high exactly while core i is in HALT.
- R4: Participating peripherals get their halt line on the same edge as the cores, and lose it on the release edge.
- R5: A halted system is released on the first edge at which every core in DEBUG has its ready input high. On that edge all core and peripheral halt lines drop and every state returns to RUN.
- R6: On the release edge, core_resume_o goes high for exactly one cycle on each core that was in DEBUG, and on no other core.
- R7: part_mask_i bits [NC-1:0] select cores and bits [NC+NP-1:NC] select peripherals. The mask is sampled on the edge that starts a halt. A unit with its bit clear is never halted, stays in RUN, and its debug entry starts nothing.
- R8: While the system is halted, a rising synchronized entry on a core in HALT moves it to DEBUG. The release then also waits for that core's ready input.
- R9: If a core joins as in R8 on the same edge at which the release condition holds, the join wins. No resume pulse is issued and no halt line drops on that edge.
- R10: halt_src_o holds, as one bit per core, the cores whose entry started the current halt, including cores that entered together. It is held while halted and cleared on the release edge.
- R11: Only a rising edge of the synchronized entry counts. An entry input that is still high after the release does not start a new halt.
- R12: Under reset all states are RUN, and all halt, resume and source outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dbg_entry_i | input | NC (4) | Per-core flag, high while the core is in its own debug state (asynchronous) |
| dbg_ready_i | input | NC (4) | Per-core flag from the debugger: ready to resume |
| part_mask_i | input | NC+NP (6) | Participation mask: cores in the low bits, peripherals in the high bits |
| core_halt_o | output | NC (4) | Per-core halt line |
| periph_halt_o | output | NP (2) | Per-peripheral halt line |
| core_resume_o | output | NC (4) | Per-core one-cycle resume pulse |
| core_state_o | output | 2*NC (8) | Per-core state code (2 bits per core) |
| halt_src_o | output | NC (4) | Sticky record of the cores that started the halt |

## Verification
Two functions can fall on the same edge: a second core joining the halt and the release of the system. The bench provokes this by timing the joining core's entry input so that its synchronized rising edge arrives exactly when the ready input of the last debugging core goes high. It then judges the outcome: the joining core must be in DEBUG, no resume pulse may appear, and the halt lines must stay up until that core's own ready input arrives. A behavioural reference model is compared with every output on every cycle, so cases where both functions fall together elsewhere in the run are caught as well.

// File: rtl/shc_pkg.sv
// Package: shared state codes for the synchronized halt controller.
// Assumes: two-bit state field per core; the encoding is visible at the ports.
package shc_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'b00,
        ST_DEBUG = 2'b01,
        ST_HALT  = 2'b10
    } core_st_t;
endpackage

// File: rtl/shc_sync.sv
// Module: shc_sync
// Two-flop synchronizer for a vector of asynchronous single-bit flags.
// Assumes: each bit is a level that is independent of the others; no bus coherency is needed.
module shc_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stable_q;

    // Two register stages per bit, both cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= async_i;
            stable_q <= meta_q;
        end
    end

    assign sync_o = stable_q;
endmodule

// File: rtl/shc_core_ctl.sv
// Module: shc_core_ctl
// Per-core run-control state: RUN, DEBUG or HALT, plus a registered resume pulse.
// Assumes: start_i, join_i and release_i come from the central control and are
// mutually consistent (join and release never both high; start only while idle).
module shc_core_ctl
    import shc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       trig_i,
    input  logic       part_i,
    input  logic       join_i,
    input  logic       release_i,
    output logic [1:0] state_o,
    output logic       halt_o,
    output logic       resume_o
);
    core_st_t state_q;
    core_st_t state_d;

    // Next-state selection for this core.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (start_i && trig_i) begin
                    state_d = ST_DEBUG;
                end else if (start_i && part_i) begin
                    state_d = ST_HALT;
                end
            end
            ST_HALT: begin
                if (join_i) begin
                    state_d = ST_DEBUG;
                end else if (release_i) begin
                    state_d = ST_RUN;
                end
            end
            ST_DEBUG: begin
                if (release_i) begin
                    state_d = ST_RUN;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    // State register and resume pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_RUN;
            resume_o <= 1'b0;
        end else begin
            state_q  <= state_d;
            resume_o <= release_i && (state_q == ST_DEBUG);
        end
    end

    assign state_o = state_q;
    assign halt_o  = (state_q == ST_HALT);

    // R6: a resume pulse lasts a single cycle.
    p_resume_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        resume_o |=> !resume_o);

    // R6: a resume pulse only follows a cycle spent in DEBUG.
    p_resume_from_debug_r6: assert property (@(posedge clk) disable iff (!rst_n)
        resume_o |-> ($past(state_q) == ST_DEBUG));

    // R3: the state register never holds the unused code.
    p_state_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state_o != 2'b11);
endmodule

// File: rtl/shc_periph_gate.sv
// Module: shc_periph_gate
// Halt lines for the peripherals: each is set when a halt starts (if the
// peripheral participates) and cleared on release.
// Assumes: part_i is the mask latched by the central control at halt start.
module shc_periph_gate #(
    parameter int NP = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          release_i,
    input  logic [NP-1:0] mask_i,
    input  logic [NP-1:0] part_i,
    output logic [NP-1:0] halt_o
);
    for (genvar g = 0; g < NP; g++) begin : g_periph
        logic halt_q;

        // Set on halt start for participants, clear on release.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                halt_q <= 1'b0;
            end else if (start_i && mask_i[g]) begin
                halt_q <= 1'b1;
            end else if (release_i) begin
                halt_q <= 1'b0;
            end
        end

        assign halt_o[g] = halt_q;

        // R7: a halted peripheral was a participant in the latched mask.
        p_periph_part_r7: assert property (@(posedge clk) disable iff (!rst_n)
            halt_q |-> part_i[g]);
    end
endmodule

// File: rtl/sync_halt_ctrl.sv
// Module: sync_halt_ctrl (top)
// Synchronized halt and restart for NC cores and NP peripherals. A rising
// synchronized debug entry on a participating core halts all other
// participants; release waits for every debugging core's ready flag.
// Assumes: dbg_entry_i is asynchronous, dbg_ready_i and part_mask_i are
// synchronous to clk.
module sync_halt_ctrl
    import shc_pkg::*;
#(
    parameter int NC = 4,
    parameter int NP = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NC-1:0]      dbg_entry_i,
    input  logic [NC-1:0]      dbg_ready_i,
    input  logic [NC+NP-1:0]   part_mask_i,
    output logic [NC-1:0]      core_halt_o,
    output logic [NP-1:0]      periph_halt_o,
    output logic [NC-1:0]      core_resume_o,
    output logic [2*NC-1:0]    core_state_o,
    output logic [NC-1:0]      halt_src_o
);
    localparam int NT = NC + NP;

    logic [NC-1:0] entry_s;
    logic [NC-1:0] entry_prev_q;
    logic [NC-1:0] rise_w;
    logic [NC-1:0] trig_w;
    logic [NC-1:0] join_w;
    logic [NC-1:0] in_debug_w;
    logic [NC-1:0] in_halt_w;
    logic [NT-1:0] part_q;
    logic [NC-1:0] src_q;
    logic          halted_q;
    logic          start_w;
    logic          all_ready_w;
    logic          release_w;

    shc_sync #(.W(NC)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (dbg_entry_i),
        .sync_o  (entry_s)
    );

    // Previous synchronized entry, for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_prev_q <= '0;
        end else begin
            entry_prev_q <= entry_s;
        end
    end

    // Central decisions: trigger, join and release conditions.
    always_comb begin
        rise_w      = entry_s & ~entry_prev_q;
        trig_w      = rise_w & part_mask_i[NC-1:0];
        start_w     = !halted_q && (|trig_w);
        join_w      = {NC{halted_q}} & rise_w & part_q[NC-1:0] & in_halt_w;
        all_ready_w = &(~in_debug_w | dbg_ready_i);
        release_w   = halted_q && !(|join_w) && all_ready_w;
    end

    // System halt flag, latched mask and sticky source record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halted_q <= 1'b0;
            part_q   <= '0;
            src_q    <= '0;
        end else if (start_w) begin
            halted_q <= 1'b1;
            part_q   <= part_mask_i;
            src_q    <= trig_w;
        end else if (release_w) begin
            halted_q <= 1'b0;
            src_q    <= '0;
        end
    end

    for (genvar c = 0; c < NC; c++) begin : g_core
        logic [1:0] st;

        shc_core_ctl u_core (
            .clk       (clk),
            .rst_n     (rst_n),
            .start_i   (start_w),
            .trig_i    (trig_w[c]),
            .part_i    (part_mask_i[c]),
            .join_i    (join_w[c]),
            .release_i (release_w),
            .state_o   (st),
            .halt_o    (core_halt_o[c]),
            .resume_o  (core_resume_o[c])
        );

        assign core_state_o[2*c +: 2] = st;
        assign in_debug_w[c]          = (st == ST_DEBUG);
        assign in_halt_w[c]           = (st == ST_HALT);
    end

    shc_periph_gate #(.NP(NP)) u_periph (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_w),
        .release_i (release_w),
        .mask_i    (part_mask_i[NT-1:NC]),
        .part_i    (part_q[NT-1:NC]),
        .halt_o    (periph_halt_o)
    );

    assign halt_src_o = src_q;

    // R5: after a release every halt line is down.
    p_release_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        release_w |=> (core_halt_o == '0) && (periph_halt_o == '0));

    // R9: a join cycle produces no resume pulse.
    p_join_defers_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|join_w) |=> (core_resume_o == '0));

    // R10: the source record holds while the system stays halted.
    p_src_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_q && !release_w) |=> $stable(halt_src_o));

    // R7: a core outside the latched mask is never halted.
    p_core_unmasked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (core_halt_o & ~part_q[NC-1:0]) == '0);
endmodule

// File: tb/sim_sync_halt_ctrl.sv
module sim_sync_halt_ctrl;
    localparam int NC = 4;
    localparam int NP = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NC-1:0] entry = '0;
    logic [NC-1:0] ready = '0;
    logic [NC+NP-1:0] mask = '1;
    logic [NC-1:0] c_halt;
    logic [NP-1:0] p_halt;
    logic [NC-1:0] resume;
    logic [2*NC-1:0] state;
    logic [NC-1:0] src;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit cmp_on = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sync_halt_ctrl #(.NC(NC), .NP(NP)) u0 (
        .clk(clk), .rst_n(rst_n), .dbg_entry_i(entry), .dbg_ready_i(ready),
        .part_mask_i(mask), .core_halt_o(c_halt), .periph_halt_o(p_halt),
        .core_resume_o(resume), .core_state_o(state), .halt_src_o(src)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // Behavioural reference model: per-core state as integers (0 run, 1 debug, 2 halt).
    int ms[NC];
    bit s1[NC], s2[NC], pv[NC];
    bit mh;
    logic [NC+NP-1:0] mp;
    logic [NC-1:0] msrc, mres;
    logic [NP-1:0] mper;

    always @(posedge clk) begin
        bit r[NC];
        bit st, jn, rel;
        cycles++;
        if (!rst_n) begin
            for (int i = 0; i < NC; i++) begin ms[i] = 0; s1[i] = 0; s2[i] = 0; pv[i] = 0; end
            mh = 0; mp = '0; msrc = '0; mres = '0; mper = '0;
        end else begin
            st = 0; jn = 0; rel = 1; mres = '0;
            for (int i = 0; i < NC; i++) begin
                r[i] = s2[i] && !pv[i];
                if (!mh && r[i] && mask[i]) st = 1;
            end
            if (!mh) begin
                if (st) begin
                    mh = 1; mp = mask; mper = mask[NC +: NP];
                    for (int i = 0; i < NC; i++) begin
                        msrc[i] = r[i] && mask[i];
                        ms[i] = msrc[i] ? 1 : (mask[i] ? 2 : 0);
                    end
                end
            end else begin
                for (int i = 0; i < NC; i++) begin
                    if (ms[i] == 2 && r[i] && mp[i]) jn = 1;
                    if (ms[i] == 1 && !ready[i]) rel = 0;
                end
                if (jn) begin
                    for (int i = 0; i < NC; i++)
                        if (ms[i] == 2 && r[i] && mp[i]) ms[i] = 1;
                end else if (rel) begin
                    for (int i = 0; i < NC; i++) begin
                        if (ms[i] == 1) mres[i] = 1;
                        ms[i] = 0;
                    end
                    mh = 0; mper = '0; msrc = '0;
                end
            end
            for (int i = 0; i < NC; i++) begin
                pv[i] = s2[i]; s2[i] = s1[i]; s1[i] = entry[i];
            end
        end
    end

    // Compare every output with the model on every cycle, away from the edge.
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            logic [2*NC-1:0] est;
            logic [NC-1:0] eh;
            for (int i = 0; i < NC; i++) begin
                est[2*i +: 2] = 2'(ms[i]);
                eh[i] = (ms[i] == 2);
            end
            chk("R3 model state", 32'(state), 32'(est));
            chk("R2 model core halt", 32'(c_halt), 32'(eh));
            chk("R4 model periph halt", 32'(p_halt), 32'(mper));
            chk("R6 model resume", 32'(resume), 32'(mres));
            chk("R10 model source", 32'(src), 32'(msrc));
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        // R12: reset state
        chk("R12 state", 32'(state), 0);
        chk("R12 halt", 32'(c_halt), 0);
        chk("R12 resume/src", 32'({resume, src, p_halt}), 0);
        rst_n = 1'b1;
        cmp_on = 1;
        step(2);

        // R1/R2/R4/R10: core 1 enters debug, all participate
        mask = '1;
        entry[1] = 1'b1;
        step(2);
        chk("R1 halt not before third edge", 32'(c_halt), 0);
        step(1);
        chk("R1 halt on third edge", 32'(c_halt), 32'h0D);
        chk("R2 state", 32'(state), 32'b10_10_01_10);
        chk("R4 periph halt", 32'(p_halt), 32'h3);
        chk("R10 source", 32'(src), 32'h2);

        // R8: core 2 joins while halted
        entry[2] = 1'b1;
        step(3);
        chk("R8 join state", 32'(state), 32'b10_01_01_10);
        ready[1] = 1'b1;
        step(2);
        chk("R8 waits for joined core", 32'(resume), 0);
        chk("R8 still halted", 32'(c_halt), 32'h9);

        // R9: core 3 joins on the same edge that core 2 becomes ready
        entry[3] = 1'b1;
        step(2);
        ready[2] = 1'b1;
        step(1);
        chk("R9 join wins state", 32'(state), 32'b01_01_01_10);
        chk("R9 no resume", 32'(resume), 0);
        chk("R9 periph held", 32'(p_halt), 32'h3);

        // R5/R6/R10: release
        ready[3] = 1'b1;
        step(1);
        chk("R6 resume pulse", 32'(resume), 32'hE);
        chk("R5 halts clear", 32'({c_halt, p_halt}), 0);
        chk("R5 all run", 32'(state), 0);
        chk("R10 source cleared", 32'(src), 0);
        step(1);
        chk("R6 pulse one cycle", 32'(resume), 0);

        // R11: entries still high, no retrigger
        step(4);
        chk("R11 no retrigger", 32'(c_halt), 0);
        chk("R11 state run", 32'(state), 0);
        entry = '0;
        ready = '0;
        step(4);

        // R7: mask cores 0,1 and periph 1; non-participant entry ignored
        mask = 6'b10_0011;
        entry[2] = 1'b1;
        step(4);
        chk("R7 unmasked entry ignored", 32'({c_halt, p_halt, state}), 0);
        entry[2] = 1'b0;
        entry[0] = 1'b1;
        step(3);
        chk("R7 only participant halted", 32'(c_halt), 32'h2);
        chk("R7 periph mask", 32'(p_halt), 32'h2);
        chk("R7 states", 32'(state), 32'b00_00_10_01);
        ready[0] = 1'b1;
        step(1);
        chk("R6 resume core 0", 32'(resume), 32'h1);
        entry = '0;
        ready = '0;
        step(4);

        // R10/R5: two cores enter together, release waits for both
        mask = '1;
        entry = 4'b1001;
        step(3);
        chk("R10 joint source", 32'(src), 32'h9);
        chk("R2 joint state", 32'(state), 32'b01_10_10_01);
        ready[0] = 1'b1;
        step(2);
        chk("R5 waits for all ready", 32'(c_halt), 32'h6);
        ready[3] = 1'b1;
        step(1);
        chk("R6 joint resume", 32'(resume), 32'h9);
        chk("R5 joint release", 32'({c_halt, p_halt}), 0);
        entry = '0;
        ready = '0;
        step(4);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule